// File: doc/BRIEF.md
# I2C Master Stop Generator with Collision Detection

This block produces the Stop condition of an I2C master and watches the bus for another master while it does so. A one-cycle request starts the sequence. The block assumes it already holds SCL low. It drives each bus line through an active-high pull-low enable, since the lines are open-drain. It reads both lines back through a two-flop synchronizer.

The sequence has three timed phases, each set by a 7-bit reload value. First SDA is held low. Then SCL is let go and timed while high. Then SDA is let go and checked. The SCL-high phase starts only once the released clock line reads high, so a slave that stretches the clock delays it. The block ends in one of two ways. If SDA reads high at the end, the Stop has succeeded and the block raises a stop-seen flag and a sticky completion interrupt. If another device holds SDA low at the end, or pulls SCL low while SCL should be high, the block raises a sticky bus-collision flag instead. In both cases it releases both lines and drops busy.

Top module: `i2c_stop_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, stop_seen, done_irq and bcol_flag are 0 and both pull-low enables are 0.
- R2: A stop_req pulse while idle makes busy, sda_drive_low and scl_drive_low all 1 in the following cycle, and clears stop_seen.
- R3: scl_drive_low stays 1 until the interval timer has expired and the synchronized SDA reads 0. With no stretching and reload 3, SCL is held low for exactly 4 cycles after the request edge.
- R4: After SCL is released, the SCL-high interval starts only when the synchronized SCL reads 1. Each interval lasts max(reload,1)+1 cycles from its loading edge to the edge that acts on it, so holding SCL low lengthens the stop.
- R5: At the end of the SDA-release interval, a synchronized SDA of 1 sets stop_seen and done_irq, clears busy and releases both lines. Both enables are 0 whenever busy is 0.
- R6: At the end of the SDA-release interval, a synchronized SDA of 0 sets bcol_flag, clears busy and releases both lines, and leaves stop_seen and done_irq at 0.
- R7: A synchronized SCL of 0 during the SCL-high interval sets bcol_flag and ends the sequence at once, with stop_seen and done_irq left at 0.
- R8: done_irq and bcol_flag stay set until a one-cycle pulse on done_irq_clr or bcol_clr respectively clears them. A new setting event wins over a clear in the same cycle.
- R9: A stop_req that arrives while busy is 1 is ignored. The sequence in progress continues unchanged, and no new sequence follows it.
- R10: A reload value of 0 gives the same timing as a reload value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | One-cycle pulse that starts a Stop |
| reload | input | RELOAD_W (7) | Interval reload value |
| sda_in | input | 1 | Sensed SDA line level |
| scl_in | input | 1 | Sensed SCL line level |
| done_irq_clr | input | 1 | Pulse that clears done_irq |
| bcol_clr | input | 1 | Pulse that clears bcol_flag |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| stop_busy | output | 1 | Stop sequence in progress |
| stop_seen | output | 1 | Last Stop completed on the bus |
| done_irq | output | 1 | Sticky completion interrupt |
| bcol_flag | output | 1 | Sticky bus-collision flag |

## Verification
The bench uses the default 7-bit reload width and two synchronizer stages. It runs reload values of 0 and 1, where the synchronizer latency rather than the timer decides the SDA-low and SDA-check phases. It runs reload 3, where the timer decides. It runs reload 20, which leaves an SCL-high window long enough to inject a clock pull-down from outside. The two-stage setting also lets the bench stretch the clock for a known number of cycles and see it reflected in the busy time.

// File: rtl/stopgen_pkg.sv
// Package: shared state encoding for the stop generator.
// Assumes nothing beyond being compiled before the modules that import it.
package stopgen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,  // lines released, waiting for a request
        ST_HOLD_SDA = 3'd1,  // SDA and SCL held low, first interval
        ST_WAIT_SCL = 3'd2,  // SCL released, waiting for it to read high
        ST_SCL_HIGH = 3'd3,  // SCL high interval, watching for a pull-down
        ST_SDA_REL  = 3'd4   // SDA released, final interval then check
    } stop_state_e;

endpackage

// File: rtl/stopgen_sync.sv
// Module: multi-bit, multi-stage synchronizer for the sensed bus lines.
// Assumes lines idle high, so every stage resets to 1.
module stopgen_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= din;
                end
            end else begin : g_next
                // Pass the value one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/stopgen_brg.sv
// Module: interval timer loaded with the reload value and counting to zero.
// Assumes the caller pulses load for one cycle. A reload of 0 loads 1.
// expired is high whenever the count rests at zero.
module stopgen_brg #(
    parameter int RELOAD_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [RELOAD_W-1:0] reload,
    output logic                expired
);

    localparam logic [RELOAD_W-1:0] ONE = RELOAD_W'(1);

    logic [RELOAD_W-1:0] cnt_q;
    logic [RELOAD_W-1:0] load_val;

    // Clamp a zero reload to the shortest interval.
    always_comb load_val = (reload == '0) ? ONE : reload;

    // Load on request, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
    end

    assign expired = (cnt_q == '0);

    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

    assert_load_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q != '0));

endmodule

// File: rtl/stopgen_fsm.sv
// Module: sequencer of the Stop phases and the collision checks.
// Assumes synchronized line levels and an interval timer that reports expiry.
// After SDA is released it waits SYNC_STAGES cycles so the check does not
// read the level from before the release.
module stopgen_fsm
    import stopgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic sda_s,
    input  logic scl_s,
    input  logic tmr_expired,
    output logic tmr_load,
    output logic sda_drive_low,
    output logic scl_drive_low,
    output logic busy,
    output logic ok_evt,
    output logic bcol_evt
);

    localparam int SW = $clog2(SYNC_STAGES + 1);
    localparam logic [SW-1:0] SETTLE_INIT = SW'(SYNC_STAGES);

    stop_state_e state_q, state_d;
    logic [SW-1:0] settle_q, settle_d;

    // Next-state, timer load and outcome decisions.
    always_comb begin
        state_d  = state_q;
        settle_d = (settle_q != '0) ? settle_q - SW'(1) : settle_q;
        tmr_load = 1'b0;
        ok_evt   = 1'b0;
        bcol_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (stop_req) begin
                    state_d  = ST_HOLD_SDA;
                    tmr_load = 1'b1;
                end
            end
            ST_HOLD_SDA: begin
                if (tmr_expired && !sda_s) state_d = ST_WAIT_SCL;
            end
            ST_WAIT_SCL: begin
                if (scl_s) begin
                    state_d  = ST_SCL_HIGH;
                    tmr_load = 1'b1;
                end
            end
            ST_SCL_HIGH: begin
                if (!scl_s) begin
                    bcol_evt = 1'b1;
                    state_d  = ST_IDLE;
                end else if (tmr_expired) begin
                    state_d  = ST_SDA_REL;
                    tmr_load = 1'b1;
                    settle_d = SETTLE_INIT;
                end
            end
            ST_SDA_REL: begin
                if (tmr_expired && settle_q == '0) begin
                    ok_evt   = sda_s;
                    bcol_evt = !sda_s;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and settle counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            settle_q <= '0;
        end else begin
            state_q  <= state_d;
            settle_q <= settle_d;
        end
    end

    // Line enables and busy, decoded from the state register.
    always_comb begin
        busy          = (state_q != ST_IDLE);
        scl_drive_low = (state_q == ST_HOLD_SDA);
        sda_drive_low = (state_q == ST_HOLD_SDA) || (state_q == ST_WAIT_SCL) ||
                        (state_q == ST_SCL_HIGH);
    end

    assert_scl_after_sda_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low) |-> !$past(sda_s));

    assert_single_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_evt && bcol_evt));

    assert_req_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop_req && !ok_evt && !bcol_evt) |=> busy);

endmodule

// File: rtl/i2c_stop_gen.sv
// Module: top of the I2C master Stop generator.
// Assumes SCL is held low by this master when stop_req arrives. Holds the
// sticky result flags and wires synchronizer, timer and sequencer.
module i2c_stop_gen #(
    parameter int RELOAD_W    = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_req,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                sda_in,
    input  logic                scl_in,
    input  logic                done_irq_clr,
    input  logic                bcol_clr,
    output logic                sda_drive_low,
    output logic                scl_drive_low,
    output logic                stop_busy,
    output logic                stop_seen,
    output logic                done_irq,
    output logic                bcol_flag
);

    logic [1:0] lines_s;
    logic       tmr_load, tmr_expired;
    logic       ok_evt, bcol_evt;
    logic       accept;

    stopgen_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .dout (lines_s)
    );

    stopgen_brg #(.RELOAD_W(RELOAD_W)) u_brg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .reload (reload),
        .expired(tmr_expired)
    );

    stopgen_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_req     (stop_req),
        .sda_s        (lines_s[0]),
        .scl_s        (lines_s[1]),
        .tmr_expired  (tmr_expired),
        .tmr_load     (tmr_load),
        .sda_drive_low(sda_drive_low),
        .scl_drive_low(scl_drive_low),
        .busy         (stop_busy),
        .ok_evt       (ok_evt),
        .bcol_evt     (bcol_evt)
    );

    // A request counts only when the sequencer is idle.
    assign accept = stop_req && !stop_busy;

    // Sticky result flags: setting events win over software clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_seen <= 1'b0;
            done_irq  <= 1'b0;
            bcol_flag <= 1'b0;
        end else begin
            if (ok_evt)      stop_seen <= 1'b1;
            else if (accept) stop_seen <= 1'b0;
            if (ok_evt)            done_irq <= 1'b1;
            else if (done_irq_clr) done_irq <= 1'b0;
            if (bcol_evt)      bcol_flag <= 1'b1;
            else if (bcol_clr) bcol_flag <= 1'b0;
        end
    end

    assert_bcol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bcol_flag && !bcol_clr) |=> bcol_flag);

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq && !done_irq_clr) |=> done_irq);

    assert_no_stop_on_bcol_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bcol_flag) |-> !$rose(stop_seen));

    assert_idle_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_busy |-> (!sda_drive_low && !scl_drive_low));

endmodule

// File: tb/i2c_stop_gen_tb_top.sv
// Bench: behavioural cycle model compared every clock plus directed checks.
`timescale 1ns/1ps
module i2c_stop_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic [6:0] reload = 7'd3;
    logic       done_irq_clr = 1'b0;
    logic       bcol_clr = 1'b0;
    logic       ext_sda_low = 1'b0;
    logic       ext_scl_low = 1'b0;
    logic       sda_in, scl_in;
    logic       sda_drive_low, scl_drive_low, stop_busy, stop_seen, done_irq, bcol_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign sda_in = !(sda_drive_low || ext_sda_low);
    assign scl_in = !(scl_drive_low || ext_scl_low);

    i2c_stop_gen dut_i (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .reload(reload),
        .sda_in(sda_in), .scl_in(scl_in), .done_irq_clr(done_irq_clr),
        .bcol_clr(bcol_clr), .sda_drive_low(sda_drive_low),
        .scl_drive_low(scl_drive_low), .stop_busy(stop_busy),
        .stop_seen(stop_seen), .done_irq(done_irq), .bcol_flag(bcol_flag)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int  m_state = 0, m_cnt = 0, m_settle = 0;
    int  m_seen = 0, m_irq = 0, m_bcol = 0;
    int  sp[2] = '{1, 1};
    int  cp[2] = '{1, 1};
    bit  started = 0;
    int  c_rst_n = 0, c_req = 0, c_reload = 3, c_sda = 1, c_scl = 1, c_iclr = 0, c_bclr = 0;

    // Advance the model on each rising edge from inputs captured earlier.
    always @(posedge clk) begin
        int sda_u, scl_u, n_settle, ld, ok, col;
        bit expd;
        started = 1;
        if (c_rst_n == 0) begin
            m_state = 0; m_cnt = 0; m_settle = 0;
            m_seen = 0; m_irq = 0; m_bcol = 0;
            sp = '{1, 1}; cp = '{1, 1};
        end else begin
            sda_u = sp[1]; scl_u = cp[1];
            sp[1] = sp[0]; sp[0] = c_sda;
            cp[1] = cp[0]; cp[0] = c_scl;
            expd = (m_cnt == 0);
            n_settle = (m_settle > 0) ? m_settle - 1 : 0;
            ld = 0; ok = 0; col = 0;
            case (m_state)
                0: if (c_req) begin m_state = 1; ld = 1; m_seen = 0; end
                1: if (expd && sda_u == 0) m_state = 2;
                2: if (scl_u == 1) begin m_state = 3; ld = 1; end
                3: if (scl_u == 0) begin col = 1; m_state = 0; end
                   else if (expd) begin m_state = 4; ld = 1; n_settle = 2; end
                4: if (expd && m_settle == 0) begin
                       if (sda_u == 1) ok = 1; else col = 1;
                       m_state = 0;
                   end
                default: m_state = 0;
            endcase
            m_settle = n_settle;
            if (ld) m_cnt = (c_reload == 0) ? 1 : c_reload;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            if (ok) begin m_seen = 1; m_irq = 1; end
            else if (c_iclr) m_irq = 0;
            if (col) m_bcol = 1;
            else if (c_bclr) m_bcol = 0;
        end
    end

    // Compare away from the edge, then capture inputs for the next edge.
    always begin
        @(negedge clk); #2;
        if (started) begin
            chk("R9", stop_busy, m_state != 0, "busy vs model");
            chk("R3", scl_drive_low, m_state == 1, "scl_drive_low vs model");
            chk("R5", sda_drive_low, m_state >= 1 && m_state <= 3, "sda_drive_low vs model");
            chk("R5", stop_seen, m_seen, "stop_seen vs model");
            chk("R8", done_irq, m_irq, "done_irq vs model");
            chk("R6", bcol_flag, m_bcol, "bcol_flag vs model");
        end
        c_rst_n = rst_n; c_req = stop_req; c_reload = reload;
        c_sda = sda_in; c_scl = scl_in; c_iclr = done_irq_clr; c_bclr = bcol_clr;
    end

    // ---------------- stimulus helpers ----------------
    task automatic run_stop(output int busy_n, output int scl_n);
        busy_n = 0; scl_n = 0;
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0; #4;
        chk("R2", {stop_busy, sda_drive_low, scl_drive_low}, 7, "enables after request");
        chk("R2", stop_seen, 0, "stop_seen cleared on start");
        while (stop_busy === 1'b1 && busy_n < 5000) begin
            busy_n++;
            if (scl_drive_low) scl_n++;
            @(negedge clk); #4;
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) done_irq_clr = 1'b1; else bcol_clr = 1'b1;
        @(negedge clk);
        done_irq_clr = 1'b0; bcol_clr = 1'b0;
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base_n, scl_n, n0, n1, s0, s1, st_n, dummy;
        repeat (3) @(negedge clk);
        #4;
        chk("R1", {stop_busy, stop_seen, done_irq, bcol_flag, sda_drive_low, scl_drive_low}, 0, "flags in reset");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #4;
        chk("R1", {stop_busy, stop_seen, done_irq, bcol_flag, sda_drive_low, scl_drive_low}, 0, "flags after reset");

        // Normal stop, reload 3.
        reload = 7'd3;
        run_stop(base_n, scl_n);
        chk("R3", scl_n, 4, "SCL low cycles with reload 3");
        chk("R5", {stop_seen, done_irq, bcol_flag}, 6, "success flags");
        chk("R5", {sda_drive_low, scl_drive_low}, 0, "lines released after success");

        // Completion interrupt is sticky until cleared.
        repeat (5) @(negedge clk);
        #4 chk("R8", done_irq, 1, "done_irq held");
        pulse(0); #4;
        chk("R8", done_irq, 0, "done_irq cleared");
        chk("R5", stop_seen, 1, "stop_seen unaffected by irq clear");

        // Reload 0 behaves as reload 1.
        reload = 7'd0; run_stop(n0, s0);
        reload = 7'd1; run_stop(n1, s1);
        chk("R10", n0, n1, "busy length reload 0 vs 1");
        chk("R10", s0, s1, "SCL low length reload 0 vs 1");
        pulse(0);

        // Clock stretching delays the SCL-high interval.
        reload = 7'd3;
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        st_n = 1;
        while (scl_drive_low === 1'b1) begin @(negedge clk); st_n++; end
        ext_scl_low = 1'b1;
        repeat (12) begin @(negedge clk); st_n++; end
        ext_scl_low = 1'b0;
        while (stop_busy === 1'b1 && st_n < 5000) begin @(negedge clk); st_n++; end
        #4;
        chk("R4", st_n > base_n + 10, 1, "stretched stop lasts longer");
        chk("R4", {stop_seen, bcol_flag}, 2, "stretched stop still succeeds");
        pulse(0);

        // Collision: SDA held low by another device.
        ext_sda_low = 1'b1;
        run_stop(dummy, scl_n);
        ext_sda_low = 1'b0;
        #1;
        chk("R6", {bcol_flag, stop_seen, done_irq}, 4, "SDA-low collision flags");
        chk("R6", {sda_drive_low, scl_drive_low}, 0, "lines released after collision");
        repeat (5) @(negedge clk);
        #4 chk("R8", bcol_flag, 1, "bcol held");
        pulse(1); #4;
        chk("R8", bcol_flag, 0, "bcol cleared");

        // Collision: SCL pulled low during the SCL-high interval.
        reload = 7'd20;
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        while (scl_drive_low === 1'b1) @(negedge clk);
        repeat (6) @(negedge clk);
        ext_scl_low = 1'b1;
        repeat (3) @(negedge clk);
        ext_scl_low = 1'b0; #4;
        chk("R7", {bcol_flag, stop_seen, done_irq, stop_busy}, 8, "SCL-low collision flags");
        pulse(1);

        // Request during busy is ignored.
        reload = 7'd3;
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        repeat (4) @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        while (stop_busy === 1'b1) @(negedge clk);
        repeat (3) @(negedge clk);
        #4;
        chk("R9", stop_busy, 0, "no second sequence after ignored request");
        chk("R9", stop_seen, 1, "first sequence completed");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule